// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block converts a single PWM command into two gate-enable signals for a synchronous buck half-bridge: one for the high-side switch and one for the low-side switch. The high-side enable follows the PWM command. The low-side enable is its complement. Dead time is inserted between them, so the two enables are never high together.

The dead time differs in the two directions. When PWM falls, the high-side enable drops first. The low-side enable then waits for a digital flag reporting that the switch node has collapsed. If that flag does not arrive within a timeout, the low side is enabled anyway and a sticky status bit records the event. When PWM rises, the low-side enable drops first. The high-side enable then waits for a flag reporting that the low-side drive has fallen. After that flag, a fixed number of clock cycles must also pass.

An active-low enable input forces both outputs off. All four inputs are resynchronised with two flops before use. After reset, and whenever the block is re-enabled, the sequencer starts with both outputs off. It then moves towards the current PWM level through the normal dead-time path.

Top module: `nonoverlap_gate_seq`

## Requirements
- R1: While enabled and settled, `hs_gate_o` is high exactly when the PWM command is high. It goes low on the 3rd rising clock edge after `pwm_i` falls.
- R2: While enabled and settled, `ls_gate_o` is high exactly when the PWM command is low. It goes low on the 3rd rising clock edge after `pwm_i` rises.
- R3: While `run_n_i` is low (synchronised), both outputs are low whatever `pwm_i` and the flags do.
- R4: After PWM falls, `ls_gate_o` stays low until the synchronised `node_low_i` flag is high. It then rises on the following edge, unless the timeout of R9 fires first.
- R5: After PWM rises, `hs_gate_o` stays low until the synchronised `drv_low_i` flag has been seen with PWM still high.
- R6: After the edge at which the synchronised `drv_low_i` is first acted on, the high side stays off for exactly `HOLD_CYC` more edges and rises on the last of them. With the default `HOLD_CYC`=4 and `drv_low_i` already high, `hs_gate_o` rises on the 8th edge after `pwm_i` rises.
- R7: `hs_gate_o` and `ls_gate_o` are never high in the same cycle.
- R8: If PWM falls while the high-side hold is still counting, the pending high-side turn-on is abandoned and `hs_gate_o` never rises. The falling path starts instead, and a later rise counts the full hold again.
- R9: If the switch node flag does not arrive within `NODE_TMO_CYC` cycles of waiting (default 12), `ls_gate_o` rises anyway on that edge and `tmo_flag_o` goes high. `tmo_flag_o` then stays high until reset.
- R10: Reset (synchronous, active high) forces both outputs and `tmo_flag_o` low. After reset or re-enable, the block follows the current PWM level only through the R4/R5/R6 dead-time path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | PWM command, asynchronous |
| run_n_i | input | 1 | Active-low output disable (low forces both gates off) |
| node_low_i | input | 1 | Switch node below threshold flag |
| drv_low_i | input | 1 | Low-side drive has fallen flag |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| tmo_flag_o | output | 1 | Sticky switch-node timeout indication |

## Verification
A walked sequence of input patterns covers the following cases:
- a full PWM cycle with both feedback flags answering;
- PWM toggling while disabled;
- re-enabling with PWM high and with PWM low.

Together these separate the steady in-phase and complementary behaviour from the forced-off behaviour and from the resume path.

Directed patterns then check the exact edge at which each output moves. One pattern drops PWM in the middle of the high-side hold, which distinguishes a correct abort from a counter that fires anyway. Another withholds the switch node flag, which distinguishes the timeout path from waiting forever. A monitor watches every cycle for overlapping enables.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_WAIT_NODE = 3'd1,
        ST_LOW_ON    = 3'd2,
        ST_WAIT_DRV  = 3'd3,
        ST_HOLD      = 3'd4,
        ST_HIGH_ON   = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic pwm;
        logic en;
        logic node_low;
        logic drv_low;
    } seq_in_t;

    localparam int SEQ_IN_W = $bits(seq_in_t);

    function automatic int cnt_bits(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) chain[0] <= '0;
        else       chain[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) chain[s] <= '0;
            else       chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/gs_dwell_timer.sv
module gs_dwell_timer #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clear_i,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i)               cnt_o <= '0;
        else if (run_i && cnt_o != '1)      cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/gs_phase_fsm.sv
module gs_phase_fsm
    import gate_seq_pkg::*;
#(
    parameter int HOLD_CYC     = 4,
    parameter int NODE_TMO_CYC = 12,
    parameter int CW           = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  seq_in_t       in_s,
    input  logic [CW-1:0] cnt_i,
    output logic          clear_o,
    output logic          run_o,
    output logic          hs_o,
    output logic          ls_o,
    output logic          tmo_sticky_o
);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST  = CW'(NODE_TMO_CYC - 1);

    seq_state_t state_q, state_d;
    logic       tmo_hit;

    always_comb begin
        state_d = state_q;
        tmo_hit = 1'b0;
        if (!in_s.en) begin
            state_d = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF:       state_d = in_s.pwm ? ST_WAIT_DRV : ST_WAIT_NODE;
                ST_WAIT_NODE: begin
                    if (in_s.pwm)                state_d = ST_WAIT_DRV;
                    else if (in_s.node_low)      state_d = ST_LOW_ON;
                    else if (cnt_i == TMO_LAST) begin
                        state_d = ST_LOW_ON;
                        tmo_hit = 1'b1;
                    end
                end
                ST_LOW_ON:    if (in_s.pwm) state_d = ST_WAIT_DRV;
                ST_WAIT_DRV: begin
                    if (!in_s.pwm)               state_d = ST_WAIT_NODE;
                    else if (in_s.drv_low)       state_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (!in_s.pwm)               state_d = ST_WAIT_NODE;
                    else if (cnt_i == HOLD_LAST) state_d = ST_HIGH_ON;
                end
                ST_HIGH_ON:   if (!in_s.pwm) state_d = ST_WAIT_NODE;
                default:      state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q      <= ST_OFF;
            tmo_sticky_o <= 1'b0;
        end else begin
            state_q <= state_d;
            if (tmo_hit) tmo_sticky_o <= 1'b1;
        end
    end

    assign clear_o = (state_d != state_q);
    assign run_o   = (state_q == ST_WAIT_NODE) || (state_q == ST_HOLD);
    assign hs_o    = (state_q == ST_HIGH_ON);
    assign ls_o    = (state_q == ST_LOW_ON);

    // R7: never both enables at once
    a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (rst_i)
        !(hs_o && ls_o));

    // R3: a disabled input forces both outputs off on the next edge
    a_r3_disable_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_s.en |=> (!hs_o && !ls_o));

    // R4: low side only rises after the node flag, or through the timeout
    a_r4_ls_after_node: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ls_o) |-> ($past(in_s.node_low) || tmo_sticky_o));

    // R5: high side only rises with PWM high and the low side already off
    a_r5_hs_after_ls_off: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hs_o) |-> ($past(in_s.pwm) && !$past(ls_o)));

    // R9: the timeout status is sticky
    a_r9_sticky_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        tmo_sticky_o |=> tmo_sticky_o);
endmodule

// File: rtl/nonoverlap_gate_seq.sv
module nonoverlap_gate_seq
    import gate_seq_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int HOLD_CYC     = 4,
    parameter int NODE_TMO_CYC = 12
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pwm_i,
    input  logic run_n_i,
    input  logic node_low_i,
    input  logic drv_low_i,
    output logic hs_gate_o,
    output logic ls_gate_o,
    output logic tmo_flag_o
);
    localparam int CW = cnt_bits(HOLD_CYC, NODE_TMO_CYC);

    seq_in_t               raw_in;
    logic [SEQ_IN_W-1:0]   sync_q;
    seq_in_t               in_s;
    logic [CW-1:0]         cnt;
    logic                  cnt_clear;
    logic                  cnt_run;

    always_comb begin
        raw_in.pwm      = pwm_i;
        raw_in.en       = run_n_i;
        raw_in.node_low = node_low_i;
        raw_in.drv_low  = drv_low_i;
    end

    gs_sync #(.W(SEQ_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw_in),
        .q_o   (sync_q)
    );

    assign in_s = seq_in_t'(sync_q);

    gs_dwell_timer #(.CW(CW)) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (cnt_clear),
        .run_i   (cnt_run),
        .cnt_o   (cnt)
    );

    gs_phase_fsm #(
        .HOLD_CYC     (HOLD_CYC),
        .NODE_TMO_CYC (NODE_TMO_CYC),
        .CW           (CW)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .in_s         (in_s),
        .cnt_i        (cnt),
        .clear_o      (cnt_clear),
        .run_o        (cnt_run),
        .hs_o         (hs_gate_o),
        .ls_o         (ls_gate_o),
        .tmo_sticky_o (tmo_flag_o)
    );
endmodule

// File: tb/nonoverlap_gate_seq_bench.sv
`timescale 1ns/1ps
module nonoverlap_gate_seq_bench;
    logic clk = 1'b0;
    logic rst, pwm, run_n, node_low, drv_low;
    logic hs, ls, tmo;
    int   checks = 0;
    int   failures = 0;
    logic overlap_seen = 1'b0;

    always #2 clk = ~clk;

    nonoverlap_gate_seq u_nonoverlap_gate_seq (
        .clk_i      (clk),
        .rst_i      (rst),
        .pwm_i      (pwm),
        .run_n_i    (run_n),
        .node_low_i (node_low),
        .drv_low_i  (drv_low),
        .hs_gate_o  (hs),
        .ls_gate_o  (ls),
        .tmo_flag_o (tmo)
    );

    // vector: pwm, run_n, node_low, drv_low, wait[4:0], exp_hs, exp_ls
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        {4'b0110, 5'd6,  2'b01},  // R2 R10 settle low after reset
        {4'b1100, 5'd6,  2'b00},  // R5 rise: low side off, waits drive flag
        {4'b1101, 5'd8,  2'b10},  // R1 R6 drive flag then hold then high
        {4'b0101, 5'd6,  2'b00},  // R4 fall: waits node flag
        {4'b0111, 5'd4,  2'b01},  // R4 R2 node flag releases low side
        {4'b0011, 5'd4,  2'b00},  // R3 disable with PWM low
        {4'b1011, 5'd8,  2'b00},  // R3 PWM high while disabled
        {4'b1111, 5'd10, 2'b10},  // R10 re-enable with PWM high
        {4'b1011, 5'd4,  2'b00},  // R3 disable with PWM high
        {4'b0111, 5'd6,  2'b01}   // R10 re-enable with PWM low
    };

    always @(negedge clk) if (hs && ls) overlap_seen = 1'b1;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic hs_ever;
        rst = 1'b1; pwm = 1'b0; run_n = 1'b1; node_low = 1'b1; drv_low = 1'b0;
        step(3);
        check("R10", "reset hs", hs, 1'b0);
        check("R10", "reset ls", ls, 1'b0);
        check("R10", "reset tmo", tmo, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {pwm, run_n, node_low, drv_low} = VEC[i][10:7];
            step(int'(VEC[i][6:2]));
            check("R1/R3/R10 vector hs", $sformatf("step %0d", i), hs, VEC[i][1]);
            check("R2/R3/R10 vector ls", $sformatf("step %0d", i), ls, VEC[i][0]);
        end

        // R8: abort a pending high-side turn-on (state: low side on, flags high)
        pwm = 1'b1;
        step(4);
        pwm = 1'b0;
        hs_ever = 1'b0;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (hs) hs_ever = 1'b1;
        end
        check("R8", "hs during abort", hs_ever, 1'b0);
        check("R8", "ls after abort", ls, 1'b1);

        // R2 R5 R6: exact edges on a rise with drive flag already high
        pwm = 1'b1;
        step(2);
        check("R2", "ls before 3rd edge", ls, 1'b1);
        step(1);
        check("R5", "ls off at 3rd edge", ls, 1'b0);
        step(4);
        check("R6", "hs still held at 7th edge", hs, 1'b0);
        step(1);
        check("R6", "hs up at 8th edge", hs, 1'b1);

        // R9 R4 R1: node flag withheld on a fall
        node_low = 1'b0;
        pwm = 1'b0;
        step(2);
        check("R1", "hs before 3rd edge", hs, 1'b1);
        step(1);
        check("R1", "hs off at 3rd edge", hs, 1'b0);
        check("R9", "tmo before timeout", tmo, 1'b0);
        step(11);
        check("R4", "ls waits for node flag", ls, 1'b0);
        step(1);
        check("R9", "ls forced at timeout", ls, 1'b1);
        check("R9", "tmo set", tmo, 1'b1);
        pwm = 1'b1;
        step(10);
        check("R9", "tmo sticky", tmo, 1'b1);
        check("R1", "hs after later rise", hs, 1'b1);

        // R10: reset in mid-operation
        rst = 1'b1;
        step(1);
        check("R10", "mid reset hs", hs, 1'b0);
        check("R10", "mid reset ls", ls, 1'b0);
        check("R10", "mid reset tmo", tmo, 1'b0);
        rst = 1'b0;
        step(2);

        check("R7", "overlap seen", overlap_seen, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule